// File: doc/BRIEF.md
# Clock Channel Select-Divide-Gate Bank

This block is a bank of output clock channels. Each channel picks one of four parent clock sources, divides it by a power of two and can be turned off. All the per-channel settings sit in three shared 32-bit registers that are written and read back over a small register port.

The parents are modelled as one-cycle enable strobes in a single system clock domain. Each channel likewise produces a one-cycle output strobe. This keeps the whole bank synchronous and easy to check, and it can drive clock-enable pins downstream.

A channel keeps a small counter of the strobes seen on its selected parent. It emits an output strobe when that count reaches the divide ratio. Switching a channel off, or changing its source or ratio, starts the count again.

Top module: `clkbank_top`

## Requirements
- R1: After reset all three registers read zero. Every channel is then switched on, selects parent 0 and divides by 1, so one parent 0 strobe makes every channel strobe.
- R2: The register at byte offset 0x0 holds one switch-off bit per channel (bit i for channel i). A 1 turns the channel off. The value written reads back unchanged.
- R3: The register at byte offset 0x4 holds a 2-bit source field per channel at bits [2i+1:2i]. The field value k selects parent input bit k. The value written reads back unchanged.
- R4: The register at byte offset 0x8 holds a 2-bit ratio code n per channel at bits [2i+1:2i]. The channel strobes on every 2^n-th strobe of its selected parent, so the ratio is 1, 2, 4 or 8. The value written reads back unchanged.
- R5: An output strobe is high for exactly the one cycle that follows the clock edge at which the counted parent strobe was sampled.
- R6: A write to any offset other than 0x0, 0x4 or 0x8 changes nothing. A read of such an offset returns zero. The read data is also zero whenever no read is requested.
- R7: A channel that is switched off holds its output low in every cycle, including the cycle right after the switch-off write. Its count is held at zero, so after it is switched back on the first output comes after a full divided period.
- R8: A parent strobe in the same cycle as a source or ratio write is counted under the old settings. A strobe in the cycle after that write is discarded, and counting restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when no read is requested |
| parent_stb | input | 4 | One-cycle enable strobes of the four parent sources |
| chan_stb | output | 16 | Per-channel divided output strobes |

## Verification
A register write and a parent strobe can fall in the same cycle, and the two interact in the channel counter. The bench writes a new ratio for channel 0 while parent 0 strobes in that very cycle. It expects the output that the old divide-by-1 setting gives, then a discarded strobe in the following cycle, and then a full divide-by-2 period. In the same way, a switch-off write on channel 3 lands on a parent 3 strobe mid-count. The bench then judges that the output stays low and that, once the channel is back on, exactly eight strobes pass before the next output.

// File: rtl/clkbank_pkg.sv
// Shared constants, register selector type and address decode for the
// clock channel bank. Assumes byte addressing with 32-bit registers.
package clkbank_pkg;
    localparam int REG_W    = 32;
    localparam int SRC_N    = 4;
    localparam int SEL_W    = $clog2(SRC_N);
    localparam int DIV_W    = 2;
    localparam int CNT_W    = (1 << DIV_W) - 1;
    localparam int OFF_GATE = 'h0;
    localparam int OFF_SEL  = 'h4;
    localparam int OFF_DIV  = 'h8;

    typedef enum logic [1:0] {
        RSEL_GATE = 2'd0,
        RSEL_SRC  = 2'd1,
        RSEL_DIV  = 2'd2,
        RSEL_NONE = 2'd3
    } reg_sel_e;

    // Map a byte offset to the register it names.
    function automatic reg_sel_e decode_off(input logic [7:0] off);
        case (off)
            8'(OFF_GATE): decode_off = RSEL_GATE;
            8'(OFF_SEL):  decode_off = RSEL_SRC;
            8'(OFF_DIV):  decode_off = RSEL_DIV;
            default:      decode_off = RSEL_NONE;
        endcase
    endfunction
endpackage

// File: rtl/clkbank_regs.sv
// Register file for the clock channel bank: a switch-off word, a source
// select word and a ratio word, with combinational read-back.
// Assumes ADDR_W <= 8 and a single-cycle access per valid.
module clkbank_regs
    import clkbank_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int ADDR_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_valid,
    input  logic                    bus_write,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [REG_W-1:0]        bus_wdata,
    output logic [REG_W-1:0]        bus_rdata,
    output logic [NUM_CH-1:0]       gate_off,
    output logic [NUM_CH*SEL_W-1:0] src_sel,
    output logic [NUM_CH*DIV_W-1:0] div_code
);
    localparam int SEL_BITS = NUM_CH * SEL_W;
    localparam int DIV_BITS = NUM_CH * DIV_W;

    reg_sel_e which;
    logic     wr_en;
    logic     rd_en;

    // Decode the accessed register.
    always_comb begin
        which = decode_off(8'(bus_addr));
        wr_en = bus_valid && bus_write;
        rd_en = bus_valid && !bus_write;
    end

    // Store register writes; unmapped offsets are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_off <= '0;
            src_sel  <= '0;
            div_code <= '0;
        end else if (wr_en) begin
            case (which)
                RSEL_GATE: gate_off <= bus_wdata[NUM_CH-1:0];
                RSEL_SRC:  src_sel  <= bus_wdata[SEL_BITS-1:0];
                RSEL_DIV:  div_code <= bus_wdata[DIV_BITS-1:0];
                default:   ;
            endcase
        end
    end

    // Return the addressed register, or zero.
    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            case (which)
                RSEL_GATE: bus_rdata = REG_W'(gate_off);
                RSEL_SRC:  bus_rdata = REG_W'(src_sel);
                RSEL_DIV:  bus_rdata = REG_W'(div_code);
                default:   bus_rdata = '0;
            endcase
        end
    end

    AST_BAD_OFF_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && which == RSEL_NONE) |=> ($stable(gate_off) && $stable(src_sel) && $stable(div_code))) // R6
        else $error("write to unmapped offset changed a register");
    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en || which == RSEL_NONE) |-> bus_rdata == '0) // R6
        else $error("read data not zero");
endmodule

// File: rtl/clkbank_chan.sv
// One output channel: picks a parent strobe, counts it up to 2^code and
// fires a one-cycle strobe. A switch-off holds the count at zero and forces
// the output low. A change of source or ratio restarts the count.
// Assumes the parent strobes are synchronous to clk.
module clkbank_chan
    import clkbank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_off,
    input  logic [SEL_W-1:0] sel,
    input  logic [DIV_W-1:0] code,
    input  logic [SRC_N-1:0] parent_stb,
    output logic             out_stb
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;
    logic [SEL_W-1:0] sel_q;
    logic [DIV_W-1:0] code_q;
    logic             fire_q;
    logic             picked;
    logic             cfg_change;

    // Select the parent and derive the terminal count.
    always_comb begin
        picked     = parent_stb[sel];
        lim        = CNT_W'((1 << code) - 1);
        cfg_change = (sel != sel_q) || (code != code_q);
    end

    // Remember the settings seen in the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            code_q <= '0;
        end else begin
            sel_q  <= sel;
            code_q <= code;
        end
    end

    // Count selected parent strobes and fire at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            fire_q <= 1'b0;
        end else if (gate_off || cfg_change) begin
            cnt_q  <= '0;
            fire_q <= 1'b0;
        end else if (picked) begin
            fire_q <= (cnt_q == lim);
            cnt_q  <= (cnt_q == lim) ? '0 : cnt_q + 1'b1;
        end else begin
            fire_q <= 1'b0;
        end
    end

    // Switch-off masks a strobe fired at the same edge as the write.
    assign out_stb = fire_q && !gate_off;

    AST_GATED_CNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        gate_off |=> cnt_q == '0) // R7
        else $error("count moved while switched off");
    AST_CFG_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_change |=> (cnt_q == '0 && !out_stb)) // R8
        else $error("count not restarted on settings change");
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_change |-> cnt_q <= lim) // R4
        else $error("count above terminal value");
    AST_FIRE_AFTER_PARENT: assert property (@(posedge clk) disable iff (!rst_n)
        picked && !gate_off && !cfg_change && cnt_q == lim |=> fire_q) // R5
        else $error("missed output strobe");
endmodule

// File: rtl/clkbank_top.sv
// Top of the clock channel bank: register file plus one select-divide-gate
// channel per output. Assumes NUM_CH*2 <= 32 so each word holds all fields.
module clkbank_top
    import clkbank_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [SRC_N-1:0]  parent_stb,
    output logic [NUM_CH-1:0] chan_stb
);
    logic [NUM_CH-1:0]       gate_off;
    logic [NUM_CH*SEL_W-1:0] src_sel;
    logic [NUM_CH*DIV_W-1:0] div_code;

    clkbank_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .gate_off  (gate_off),
        .src_sel   (src_sel),
        .div_code  (div_code)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        clkbank_chan u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .gate_off   (gate_off[i]),
            .sel        (src_sel[i*SEL_W +: SEL_W]),
            .code       (div_code[i*DIV_W +: DIV_W]),
            .parent_stb (parent_stb),
            .out_stb    (chan_stb[i])
        );

        AST_GATED_OUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            gate_off[i] |-> !chan_stb[i]) // R7
            else $error("switched-off channel strobed");
    end
endmodule

// File: tb/tb_clkbank_top.sv
// Self-checking bench: a vector table for the dividers, then directed tests.
module tb_clkbank_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  parent_stb = '0;
    logic [15:0] chan_stb;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    clkbank_top dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .parent_stb(parent_stb), .chan_stb(chan_stb)
    );

    // {parent strobes, expected strobes of channels 4..0}; channels 5..15 follow channel 0
    localparam logic [8:0] VEC [0:12] = '{
        {4'hF, 5'h01}, {4'hF, 5'h03}, {4'hF, 5'h01}, {4'hF, 5'h07},
        {4'hF, 5'h01}, {4'hF, 5'h03}, {4'hF, 5'h01}, {4'hF, 5'h0F},
        {4'h2, 5'h00}, {4'h2, 5'h02}, {4'h8, 5'h00}, {4'h0, 5'h00},
        {4'h1, 5'h01}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock: drive at negedge, sample at the following negedge.
    task automatic step(input logic v, input logic w, input logic [3:0] a,
                        input logic [31:0] d, input logic [3:0] p);
        bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d; parent_stb = p;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; parent_stb = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        check("R1 outputs in reset", 32'(chan_stb), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(4'h0, r); check("R1 gate reset", r, 32'h0);
        rd(4'h4, r); check("R1 select reset", r, 32'h0);
        rd(4'h8, r); check("R1 ratio reset", r, 32'h0);
        step(0, 0, 0, 0, 4'h1);
        check("R1 R5 all channels follow parent0", 32'(chan_stb), 32'hFFFF);
        step(0, 0, 0, 0, 4'h0);
        check("R5 strobe lasts one cycle", 32'(chan_stb), 32'h0);
        rd(4'h4, r); bus_valid = 0;
        // configure: ch1 p1 /2, ch2 p2 /4, ch3 p3 /8, ch4 switched off
        step(1, 1, 4'h4, 32'h0000_00E4, 0);
        step(1, 1, 4'h8, 32'h0000_00E4, 0);
        step(1, 1, 4'h0, 32'h0000_0010, 0);
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        rd(4'h0, r); check("R2 gate readback", r, 32'h10);
        rd(4'h4, r); check("R3 select readback", r, 32'hE4);
        rd(4'h8, r); check("R4 ratio readback", r, 32'hE4);
        rd(4'h4, r); bus_valid = 1'b0;
        #1 check("R6 rdata zero without read", bus_rdata, 32'h0);
        for (int k = 0; k < 13; k++) begin
            logic [4:0] e;
            e = VEC[k][4:0];
            step(0, 0, 0, 0, VEC[k][8:5]);
            check($sformatf("R3 R4 R7 vector %0d", k), 32'(chan_stb), 32'({{11{e[0]}}, e}));
        end
        // R8: restart on source change for ch1
        step(0, 0, 0, 0, 4'h2);
        check("R8 ch1 mid count", 32'(chan_stb[1]), 32'h0);
        step(1, 1, 4'h4, 32'h0000_00E0, 0);
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 4'h1);
        check("R8 ch1 restarted no early fire", 32'(chan_stb[1]), 32'h0);
        step(0, 0, 0, 0, 4'h1);
        check("R8 ch1 fires after full period", 32'(chan_stb[1]), 32'h1);
        // R8: ratio write colliding with a parent strobe on ch0
        step(1, 1, 4'h8, 32'h0000_00E5, 4'h1);
        check("R8 collision counted under old ratio", 32'(chan_stb[0]), 32'h1);
        step(0, 0, 0, 0, 4'h1);
        check("R8 strobe after write discarded", 32'(chan_stb[0]), 32'h0);
        step(0, 0, 0, 0, 4'h1);
        check("R8 first of new period", 32'(chan_stb[0]), 32'h0);
        step(0, 0, 0, 0, 4'h1);
        check("R8 new divide by 2", 32'(chan_stb[0]), 32'h1);
        // R7: switch off ch3 mid count with a colliding strobe
        step(0, 0, 0, 0, 4'h8);
        step(0, 0, 0, 0, 4'h8);
        step(1, 1, 4'h0, 32'h0000_0018, 4'h8);
        check("R7 ch3 low after switch-off", 32'(chan_stb[3]), 32'h0);
        step(0, 0, 0, 0, 4'h8);
        check("R7 ch3 low while off", 32'(chan_stb[3]), 32'h0);
        step(1, 1, 4'h0, 32'h0000_0010, 0);
        begin
            int early = 0;
            for (int k = 0; k < 7; k++) begin
                step(0, 0, 0, 0, 4'h8);
                if (chan_stb[3]) early++;
            end
            check("R7 no output before full period", 32'(early), 32'h0);
        end
        step(0, 0, 0, 0, 4'h8);
        check("R7 output after eight strobes", 32'(chan_stb[3]), 32'h1);
        // R6: unmapped offsets
        step(1, 1, 4'hC, 32'hFFFF_FFFF, 0);
        step(1, 1, 4'h1, 32'hFFFF_FFFF, 0);
        rd(4'hC, r); check("R6 unmapped reads zero", r, 32'h0);
        rd(4'h0, r); check("R6 gate untouched", r, 32'h10);
        rd(4'h4, r); check("R6 select untouched", r, 32'hE0);
        rd(4'h8, r); check("R6 ratio untouched", r, 32'hE5);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule